// File: doc/BRIEF.md
# Free-Running Timer with Selectable Tick Source

This block is a free-running up-counter that software reads through a small word-wide register port. The counter advances by one on each cycle where the chosen tick enable is high. The choice is between a slow tick (nominally 1 MHz) and a fast tick (nominally 27 MHz). A suspend input can gate the fast tick to save power. The slow tick ignores suspend.

When the counter wraps from all ones to zero, it sets a sticky overflow flag. An interrupt output reports the flag while the interrupt enable is set. Software clears the flag by writing a one to it. The counter itself is read-only.

The register port is byte-addressed. Writes take effect at the next clock edge, and reads are combinational. Only the registered state is exposed, so every register read reflects the last clock edge.

Top module: `hires_timer`

## Requirements
- R1: After reset the counter reads 0, the overflow flag and all configuration bits read 0, and `irq` is low.
- R2: The counter reads as a zero-extended word at address 0x08. It increments by exactly one on each clock edge where the selected tick is high, and writes to 0x08 have no effect on it.
- R3: With configuration bit 1 clear, the counter advances only on `tickSlow`. `tickFast` has no effect.
- R4: With configuration bit 1 set, the counter advances only on `tickFast`. `tickSlow` has no effect.
- R5: A tick while the counter holds all ones makes it read 0 and sets the overflow flag, which reads as bit 0 of the word at 0x0C.
- R6: The overflow flag clears only on a write to 0x0C with byte enable 0 and data bit 0 set. A write of 0, or a write with byte enable 0 low, leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly while the overflow flag and configuration bit 0 (interrupt enable) are both 1.
- R8: With configuration bits 1 and 2 both set, the counter holds its value while `suspend` is high. Suspend has no effect when bit 2 is clear or when the slow tick is selected.
- R9: The configuration byte is written through byte enable 1 of the word at 0x0C. It reads back as bits 10:8 of that word, and all other bits of that word read 0. Addresses other than 0x08 and 0x0C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe |
| regWrBe | input | 4 | Byte enables of the write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| tickSlow | input | 1 | Slow tick enable |
| tickFast | input | 1 | Fast tick enable |
| suspend | input | 1 | Suspend request; may gate the fast tick |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong tick select or a wrong suspend gate shows up as a counter value at 0x08 that differs from the reference in the cycle after the first tick it mishandles. A missed or spurious wrap, or a bad clear priority, shows up on status bit 0 and on `irq` one cycle after the edge concerned. The bench keeps the counter narrow so that it wraps within the run. It compares the read word and `irq` against a behavioural model on every cycle, so any divergence is reported within one clock.

// File: rtl/hires_timer_pkg.sv
package hires_timer_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_VALUE   = 6'h08;
  localparam logic [ADDR_W-1:0] ADDR_STATCFG = 6'h0C;

  // Field positions inside the word at ADDR_STATCFG
  localparam int unsigned OVF_BIT  = 0;
  localparam int unsigned CFG_LSB  = 8;
  localparam int unsigned CFG_W    = 3;

  typedef struct packed {
    logic powerDownOnSusp;  // bit 2
    logic fastSel;          // bit 1
    logic intEn;            // bit 0
  } tmrCfg_t;

  typedef struct packed {
    logic advance;
  } tmrStrobe_t;

endpackage

// File: rtl/hires_timer_datapath.sv
module hires_timer_datapath
  import hires_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= count + 1'b1;
    end
  end

  assign wrap = strobe.advance && (count == CNT_MAX);

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> count == CNT_W'($past(count) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(count));

endmodule

// File: rtl/hires_timer_ctrl.sv
module hires_timer_ctrl
  import hires_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [3:0]        regWrBe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic              suspend,
  input  logic              wrapIn,
  input  logic [CNT_W-1:0]  countIn,
  output tmrStrobe_t        strobe,
  output tmrCfg_t           cfg,
  output logic              irq
);

  logic ovf;
  logic clearReq;
  logic cfgWr;
  logic fastGated;
  logic unusedBits;

  assign cfgWr    = regWrEn && (regAddr == ADDR_STATCFG) && regWrBe[1];
  assign clearReq = regWrEn && (regAddr == ADDR_STATCFG) && regWrBe[0]
                    && regWrData[OVF_BIT];

  assign unusedBits = ^{regWrData[DATA_W-1:CFG_LSB+CFG_W],
                        regWrData[CFG_LSB-1:OVF_BIT+1], regWrBe[3:2]};

  // Fast tick can be powered down while suspended
  assign fastGated      = tickFast && !(cfg.powerDownOnSusp && suspend);
  assign strobe.advance = cfg.fastSel ? fastGated : tickSlow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWr) begin
      cfg <= tmrCfg_t'(regWrData[CFG_LSB +: CFG_W]);
    end
  end

  // Set by wrap wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovf <= 1'b0;
    end else if (wrapIn) begin
      ovf <= 1'b1;
    end else if (clearReq) begin
      ovf <= 1'b0;
    end
  end

  assign irq = ovf && cfg.intEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_VALUE:   regRdData = DATA_W'(countIn);
      ADDR_STATCFG: begin
        regRdData[OVF_BIT] = ovf;
        regRdData[CFG_LSB +: CFG_W] = cfg;
      end
      default:      regRdData = '0;
    endcase
  end

  a_r5_wrap_sets: assert property (@(posedge clk) disable iff (!rstN)
    wrapIn |=> ovf);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovf && !clearReq |=> ovf);

  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(wrapIn));

endmodule

// File: rtl/hires_timer.sv
module hires_timer
  import hires_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  regAddr,
  input  logic        regWrEn,
  input  logic [3:0]  regWrBe,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        tickSlow,
  input  logic        tickFast,
  input  logic        suspend,
  output logic        irq
);

  tmrStrobe_t       strobe;
  tmrCfg_t          cfg;
  logic [CNT_W-1:0] count;
  logic             wrap;

  hires_timer_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrBe   (regWrBe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .tickSlow  (tickSlow),
    .tickFast  (tickFast),
    .suspend   (suspend),
    .wrapIn    (wrap),
    .countIn   (count),
    .strobe    (strobe),
    .cfg       (cfg),
    .irq       (irq)
  );

  hires_timer_datapath #(.CNT_W(CNT_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .count  (count),
    .wrap   (wrap)
  );

  a_r8_suspend_hold: assert property (@(posedge clk) disable iff (!rstN)
    cfg.fastSel && cfg.powerDownOnSusp && suspend |=> $stable(count));

endmodule

// File: tb/tb_hires_timer.sv
module tb_hires_timer;

  localparam int W = 10;
  localparam logic [W-1:0] MAXV = '1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = 6'h08;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrBe = 4'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        tickSlow = 1'b0;
  logic        tickFast = 1'b0;
  logic        suspend = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;

  // Reference model state
  logic [W-1:0] mCount = '0;
  logic         mOvf = 1'b0;
  logic [2:0]   mCfg = '0;

  always #5 clk = ~clk;

  hires_timer #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrBe(regWrBe), .regWrData(regWrData), .regRdData(regRdData),
    .tickSlow(tickSlow), .tickFast(tickFast), .suspend(suspend), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [5:0] a);
    if (a == 6'h08) return 32'(mCount);
    if (a == 6'h0C) return {21'd0, mCfg, 7'd0, mOvf};
    return 32'd0;
  endfunction

  function automatic string tagOf(logic [5:0] a);
    if (a == 6'h08) return "R2";
    return "R9";
  endfunction

  task automatic modelUpdate();
    logic tick, wrapNow, clr;
    if (mCfg[1]) tick = tickFast && !(mCfg[2] && suspend);
    else         tick = tickSlow;
    wrapNow = tick && (mCount == MAXV);
    clr = regWrEn && regAddr == 6'h0C && regWrBe[0] && regWrData[0];
    if (tick) mCount = mCount + 1'b1;
    if (wrapNow) mOvf = 1'b1;
    else if (clr) mOvf = 1'b0;
    if (regWrEn && regAddr == 6'h0C && regWrBe[1]) mCfg = regWrData[10:8];
  endtask

  task automatic step();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    check("R7", 32'(irq), 32'(mOvf && mCfg[0]));
    check(tagOf(regAddr), regRdData, expRead(regAddr));
  endtask

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    logic [5:0] keep;
    keep = regAddr;
    regAddr = a; regWrBe = be; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; regWrBe = 4'h0; regAddr = keep;
  endtask

  task automatic readCheck(string req, logic [5:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    readCheck("R1", 6'h08, 32'd0);
    readCheck("R1", 6'h0C, 32'd0);
    check("R1", 32'(irq), 32'd0);
    rstN = 1'b1;

    // R3: slow tick selected, fast ignored
    regAddr = 6'h08;
    for (int i = 0; i < 200; i++) begin
      tickSlow = 1'($urandom % 2); tickFast = 1'b1; step();
    end
    tickSlow = 1'b0; tickFast = 1'b1;
    snap = mCount;
    repeat (10) step();
    readCheck("R3", 6'h08, 32'(snap));

    // R2: write to value register ignored
    wr(6'h08, 4'hF, 32'h0000_00FF);
    readCheck("R2", 6'h08, 32'(snap));

    // R4: fast tick selected, slow ignored
    wr(6'h0C, 4'h2, 32'h0000_0200);
    regAddr = 6'h08;
    for (int i = 0; i < 50; i++) begin
      tickSlow = 1'b1; tickFast = 1'($urandom % 2); step();
    end
    tickFast = 1'b0;
    snap = mCount;
    repeat (10) step();
    readCheck("R4", 6'h08, 32'(snap));

    // R5: wrap sets overflow
    tickFast = 1'b1;
    while (mCount != MAXV) step();
    step();
    readCheck("R5", 6'h08, 32'd0);
    readCheck("R5", 6'h0C, 32'h0000_0201);

    // R7: enable interrupt
    wr(6'h0C, 4'h2, 32'h0000_0300);
    check("R7", 32'(irq), 32'd1);

    // R6: write 0 and masked write do not clear, write 1 clears
    wr(6'h0C, 4'h1, 32'h0000_0000);
    readCheck("R6", 6'h0C, 32'h0000_0301);
    wr(6'h0C, 4'h2, 32'h0000_0301);
    readCheck("R6", 6'h0C, 32'h0000_0301);
    wr(6'h0C, 4'h1, 32'h0000_0001);
    readCheck("R6", 6'h0C, 32'h0000_0300);
    check("R7", 32'(irq), 32'd0);

    // R8: suspend holds the fast-ticked counter
    wr(6'h0C, 4'h2, 32'h0000_0700);
    regAddr = 6'h08;
    suspend = 1'b1; tickFast = 1'b1;
    snap = mCount;
    repeat (20) step();
    readCheck("R8", 6'h08, 32'(snap));
    suspend = 1'b0;
    repeat (5) step();
    readCheck("R8", 6'h08, 32'(W'(snap + 5)));
    // R8: slow tick unaffected by suspend
    wr(6'h0C, 4'h2, 32'h0000_0400);
    regAddr = 6'h08;
    suspend = 1'b1; tickSlow = 1'b1; tickFast = 1'b0;
    snap = mCount;
    repeat (7) step();
    readCheck("R8", 6'h08, 32'(W'(snap + 7)));
    // R8: pd bit clear, suspend ignored on fast tick
    wr(6'h0C, 4'h2, 32'h0000_0200);
    regAddr = 6'h08;
    tickSlow = 1'b0; tickFast = 1'b1;
    snap = mCount;
    repeat (4) step();
    readCheck("R8", 6'h08, 32'(W'(snap + 4)));
    suspend = 1'b0;

    // R6: wrap coincident with clear leaves flag set
    wr(6'h0C, 4'h1, 32'h0000_0001);
    regAddr = 6'h08;
    tickFast = 1'b1;
    while (mCount != MAXV) step();
    tickFast = 1'b1;
    regAddr = 6'h0C; regWrBe = 4'h1; regWrData = 32'h1; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; tickFast = 1'b0;
    readCheck("R6", 6'h0C, 32'h0000_0201);

    // R9: unmapped addresses read zero
    readCheck("R9", 6'h10, 32'd0);
    readCheck("R9", 6'h04, 32'd0);
    readCheck("R9", 6'h09, 32'd0);
    readCheck("R9", 6'h3C, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule